// File: doc/BRIEF.md
# Sequential Add-and-Shift Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns a product of `2*WIDTH` bits. It handles one multiplier bit per iteration. A one-cycle start pulse captures both operands. The multiplicand is held in its own register. The multiplier is placed in the lower half of a double-width product register, and the upper half is cleared.

Each iteration takes two cycles. In the first cycle the block tests the product register's lowest bit. If that bit is 1, it adds the multiplicand into the upper half and keeps the adder carry. If the bit is 0, the block idles for that cycle so that both branches take the same time. In the second cycle the whole product register shifts right by one, and the kept carry enters at the top. After `WIDTH` iterations a one-cycle done pulse marks the product as valid. The latency is the same for all operand values.

The control state machine and the datapath are separate modules. The controller drives the datapath through a small bundle of strobes: an operand-load enable, an upper-half write enable, an upper-half source select, an adder operation code and a shift enable.

Top module: `addShiftMul`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `product` is all zeros.
- R2: When a computation finishes, `product` equals the unsigned product `mcandIn * mplierIn` of the operands captured with the start pulse. At width 4, 12 times 11 gives 132.
- R3: `done` goes to 1 in the cycle that is 2*WIDTH+1 cycles after the cycle in which `startPulse` was sampled high. This count does not depend on the operand values.
- R4: `done` stays high for exactly one cycle per computation.
- R5: After `done`, `product` keeps its value until the next accepted start pulse, even if the operand inputs change.
- R6: A start pulse that arrives while a computation is running is ignored. It does not change that computation's result or its latency.
- R7: A start pulse in the same cycle as `done` is accepted, so computations can run back to back with no gap.
- R8: On each right shift, the adder carry fills the vacated top bit. With both operands at all ones, the result is the full-width product and no bits are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | One-cycle request that captures the operands and starts a computation |
| mcandIn | input | WIDTH | Multiplicand, unsigned |
| mplierIn | input | WIDTH | Multiplier, unsigned |
| product | output | 2*WIDTH | Product register contents; valid from `done` until the next start |
| done | output | 1 | One-cycle pulse marking a valid product |

## Verification
A 4-bit instance is tried with every operand pair. This covers zero operands, single-bit operands and all-ones operands, so both branches of each iteration and every carry-out position are exercised. A 16-bit instance is tried with corner operands and random operand pairs. These show that the fixed latency holds whatever mix of add and no-add iterations the data produces. Pulses injected during a computation, and pulses given in the done cycle, distinguish correct start gating from a controller that restarts or misses a request.

// File: rtl/mulPkg.sv
package mulPkg;

  typedef enum logic {
    ALU_PASS = 1'b0,
    ALU_ADD  = 1'b1
  } aluOp_e;

  typedef enum logic {
    LEFT_CLEAR = 1'b0,
    LEFT_ALU   = 1'b1
  } leftSel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2
  } mulState_e;

  typedef struct packed {
    logic     loadOps;
    logic     wrLeft;
    leftSel_e leftSel;
    aluOp_e   aluOp;
    logic     shiftEn;
  } strobes_t;

endpackage

// File: rtl/mulAlu.sv
module mulAlu
  import mulPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opL,
  input  logic [WIDTH-1:0] opR,
  input  aluOp_e           aluOp,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  logic [WIDTH:0] wide;

  always_comb begin
    if (aluOp == ALU_ADD) wide = {1'b0, opL} + {1'b0, opR};
    else                  wide = {1'b0, opL};
    sum      = wide[WIDTH-1:0];
    carryOut = wide[WIDTH];
  end

endmodule

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic [WIDTH-1:0]   mcandIn,
  input  logic [WIDTH-1:0]   mplierIn,
  output logic               prodLsb,
  output logic [2*WIDTH-1:0] product
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcandReg;
  logic [WIDTH-1:0] prodLeft;
  logic [WIDTH-1:0] prodRight;
  logic             carryReg;
  logic [WIDTH-1:0] aluSum;
  logic             aluCarry;
  logic [WIDTH-1:0] leftNext;
  logic             carryNext;

  mulAlu #(.WIDTH(WIDTH)) uAlu (
    .opL      (prodLeft),
    .opR      (mcandReg),
    .aluOp    (strobes.aluOp),
    .sum      (aluSum),
    .carryOut (aluCarry)
  );

  always_comb begin
    if (strobes.leftSel == LEFT_ALU) begin
      leftNext  = aluSum;
      carryNext = aluCarry;
    end else begin
      leftNext  = '0;
      carryNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandReg  <= '0;
      prodLeft  <= '0;
      prodRight <= '0;
      carryReg  <= 1'b0;
    end else begin
      if (strobes.loadOps) begin
        mcandReg  <= mcandIn;
        prodRight <= mplierIn;
      end
      if (strobes.wrLeft) begin
        prodLeft <= leftNext;
        carryReg <= carryNext;
      end
      if (strobes.shiftEn) begin
        prodLeft  <= {carryReg, prodLeft[WIDTH-1:1]};
        prodRight <= {prodLeft[0], prodRight[WIDTH-1:1]};
        carryReg  <= 1'b0;
      end
    end
  end

  assign prodLsb = prodRight[0];
  assign product = {prodLeft, prodRight};

  // R5
  hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadOps || strobes.wrLeft || strobes.shiftEn) |=> $stable(product));

  // R8
  carry_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> product[PW-1] == $past(carryReg));

  // R2
  mcand_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadOps |=> $stable(mcandReg));

endmodule

// File: rtl/mulControl.sv
module mulControl
  import mulPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     prodLsb,
  output strobes_t strobes,
  output logic     done
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_ITER = CW'(WIDTH - 1);

  mulState_e     state;
  logic [CW-1:0] iterCnt;
  logic          lastIter;

  assign lastIter = (iterCnt == LAST_ITER);

  always_comb begin
    strobes = '{loadOps: 1'b0, wrLeft: 1'b0, leftSel: LEFT_CLEAR,
                aluOp: ALU_PASS, shiftEn: 1'b0};
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobes.loadOps = 1'b1;
          strobes.wrLeft  = 1'b1;
          strobes.leftSel = LEFT_CLEAR;
        end
      end
      ST_TEST: begin
        if (prodLsb) begin
          strobes.wrLeft  = 1'b1;
          strobes.leftSel = LEFT_ALU;
          strobes.aluOp   = ALU_ADD;
        end
      end
      ST_SHIFT: strobes.shiftEn = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            state   <= ST_TEST;
            iterCnt <= '0;
          end
        end
        ST_TEST: state <= ST_SHIFT;
        ST_SHIFT: begin
          if (lastIter) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state   <= ST_TEST;
            iterCnt <= iterCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strobes.loadOps);

  // R3
  last_shift_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && lastIter) |=> done && state == ST_IDLE);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrLeft && strobes.shiftEn));

  // R3
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TEST) |-> iterCnt <= LAST_ITER);

endmodule

// File: rtl/addShiftMul.sv
module addShiftMul
  import mulPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [WIDTH-1:0]   mcandIn,
  input  logic [WIDTH-1:0]   mplierIn,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);

  strobes_t strobes;
  logic     prodLsb;

  mulControl #(.WIDTH(WIDTH)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .prodLsb    (prodLsb),
    .strobes    (strobes),
    .done       (done)
  );

  mulDatapath #(.WIDTH(WIDTH)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .mcandIn  (mcandIn),
    .mplierIn (mplierIn),
    .prodLsb  (prodLsb),
    .product  (product)
  );

endmodule

// File: tb/sim_addShiftMul.sv
`timescale 1ns/1ps
module sim_addShiftMul;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        dvA = 1'b0;
  logic [15:0] aA = '0, bA = '0;
  logic [31:0] pA;
  logic        doneA;

  logic        dvB = 1'b0;
  logic [3:0]  aB = '0, bB = '0;
  logic [7:0]  pB;
  logic        doneB;

  int checks = 0;
  int fails  = 0;

  addShiftMul #(.WIDTH(16)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(dvA), .mcandIn(aA), .mplierIn(bA),
    .product(pA), .done(doneA));

  addShiftMul #(.WIDTH(4)) u1 (
    .clk(clk), .rstN(rstN), .startPulse(dvB), .mcandIn(aB), .mplierIn(bB),
    .product(pB), .done(doneB));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; drives the start pulse at once and returns at the
  // negedge in which done is seen high.
  task automatic run16(input logic [15:0] a, input logic [15:0] b,
                       input string tag, input bit poke);
    int cyc;
    logic [31:0] exp;
    exp = 32'(a) * 32'(b);
    aA = a; bA = b; dvA = 1'b1;
    @(negedge clk);
    dvA = 1'b0; aA = ~a; bA = b ^ 16'h5a5a;
    cyc = 1;
    while (!doneA && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (poke) dvA = (cyc == 5);
    end
    dvA = 1'b0;
    check(cyc == 33, "R3 latency w16", cyc, 33);
    check(pA == exp, tag, pA, exp);
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b,
                      input string tag, input bit poke);
    int cyc;
    logic [7:0] exp;
    exp = 8'(a) * 8'(b);
    aB = a; bB = b; dvB = 1'b1;
    @(negedge clk);
    dvB = 1'b0; aB = ~a; bB = ~b;
    cyc = 1;
    while (!doneB && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (poke) dvB = (cyc == 3);
    end
    dvB = 1'b0;
    check(cyc == 9, "R3 latency w4", cyc, 9);
    check(pB == exp, tag, pB, exp);
  endtask

  task automatic hold16(input int n);
    logic [31:0] keep;
    keep = pA;
    for (int k = 0; k < n; k++) begin
      aA = 16'(k * 7919); bA = 16'(k * 104729);
      @(negedge clk);
      check(doneA == 1'b0, "R4 done falls w16", doneA, 0);
      check(pA == keep, "R5 product held w16", pA, keep);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(doneA == 0 && pA == 0, "R1 reset w16", pA, 0);
    check(doneB == 0 && pB == 0, "R1 reset w4", pB, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(doneA == 0 && pA == 0, "R1 after release w16", pA, 0);
    check(doneB == 0 && pB == 0, "R1 after release w4", pB, 0);

    // R2 known case at width 4: 12 * 11 = 132
    run4(4'd12, 4'd11, "R2 12x11", 1'b0);
    check(pB == 8'd132, "R2 132", pB, 132);
    @(negedge clk);
    check(doneB == 1'b0, "R4 done falls w4", doneB, 0);

    // R8 all-ones at both widths
    run4(4'hf, 4'hf, "R8 ones w4", 1'b0);
    @(negedge clk);
    run16(16'hffff, 16'hffff, "R8 ones w16", 1'b0);
    hold16(3);

    // R2 corners
    run16(16'h0000, 16'hffff, "R2 zero mcand", 1'b0);
    run16(16'hffff, 16'h0000, "R2 zero mplier", 1'b0);
    run16(16'h8000, 16'h8000, "R2 top bits", 1'b0);
    run16(16'h0001, 16'habcd, "R2 unit", 1'b0);
    hold16(2);

    // R6 start pulse mid-computation is ignored
    run16(16'h1234, 16'h5678, "R6 ignored pulse w16", 1'b1);
    hold16(2);
    run4(4'd9, 4'd13, "R6 ignored pulse w4", 1'b1);
    @(negedge clk);

    // R7 back-to-back: each run starts in the previous done cycle
    run16(16'h00ff, 16'h0f0f, "R7 chain a", 1'b0);
    run16(16'hfedc, 16'h0123, "R7 chain b", 1'b0);
    run16(16'h7fff, 16'h8001, "R7 chain c", 1'b0);
    hold16(1);

    // R2 exhaustive at width 4
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run4(4'(a), 4'(b), "R2 exhaustive w4", 1'b0);
    @(negedge clk);

    // R2 / R3 random operands at width 16
    for (int k = 0; k < 250; k++)
      run16(16'($urandom), 16'($urandom), "R2 random w16", 1'b0);
    hold16(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule